// File: doc/BRIEF.md
# Fetch Byte Queue

This block sits between an instruction cache and an instruction decoder. Every cycle the cache side may offer one aligned 16-byte chunk together with the byte offset where useful code begins. The offset is zero for sequential fetch and nonzero when the chunk holds a taken-branch target. Bytes below that offset are thrown away. The remaining bytes are appended, in order, to a 32-byte queue. The fetch side never needs to know where instructions start or end.

The decoder sees the eight oldest queued bytes and a count of how many of them are valid. It answers in the same cycle with the number of bytes it used, from 0 to 8. The queue drops that many bytes at the next edge, and the bytes left over lead the next decode group. If the free space cannot take the useful part of the offered chunk, the block raises a stall and ignores the chunk. The cache port is then free for refills during those idle cycles. A flush empties the queue in one cycle, ready for a redirected fetch stream.

Top module: `fetch_byte_queue`

## Requirements
- R1: After reset the window count is 0, all window lanes read zero and the stall output is low.
- R2: A chunk accepted with offset 0 appends all 16 bytes in ascending byte order, where chunk byte j sits at fetch_data_i bits [8j+7:8j]. Its first eight bytes show in the window in the cycle after the accepting edge.
- R3: A chunk accepted with offset k appends only chunk bytes k..15, which is 16-k bytes. Offset 15 adds exactly one byte, chunk byte 15.
- R4: The window count equals the lesser of the queue occupancy and 8. Lane i (bits [8i+7:8i]) holds the i-th oldest byte, and lanes at or above the count read zero.
- R5: A consume count n removes the n oldest bytes at the next edge. The remaining bytes keep their order and stay ahead of any later bytes.
- R6: A consume count larger than the current window count is treated as the window count.
- R7: A chunk is accepted only when 16-k does not exceed 32 minus the occupancy at the start of the cycle. Otherwise fetch_stall_o is high in that cycle and the chunk leaves the queue unchanged. fetch_stall_o is never high without fetch_valid_i.
- R8: In a cycle with both an accepted chunk and a nonzero consume, the consumed bytes leave and the new bytes join behind the survivors. The new occupancy is the old occupancy minus the consumed count plus 16-k.
- R9: flush_i empties the queue at the next edge. The chunk and consume count offered in that cycle are ignored, and the stall output is low during a flush.
- R10: Capacity is 32 bytes. Two full chunks fill the queue, and a third chunk stalls until decode frees 16 or more entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the queue, drop this cycle's chunk and consume |
| fetch_valid_i | input | 1 | A chunk is offered this cycle |
| fetch_data_i | input | 128 | Aligned chunk, byte j at bits [8j+7:8j] |
| fetch_offset_i | input | 4 | First useful byte in the chunk |
| fetch_stall_o | output | 1 | Offered chunk does not fit and is not taken |
| win_data_o | output | 64 | Eight oldest queued bytes, oldest in lane 0 |
| win_count_o | output | 4 | Valid lanes in the window, 0 to 8 |
| consume_i | input | 4 | Bytes used by decode this cycle, 0 to 8 |

## Verification
The chunks are fed at offset 0, at a middle offset and at offset 15. Comparing the window against a reference byte queue shows whether dropped bytes, byte order and appended counts are right. Consume patterns of partial, full-window, zero and oversized counts separate correct shifting from clamping faults. Back-to-back full chunks against a queue near capacity test the room check and the stall at its exact boundary. Overlapping accept, consume and flush cycles expose faults in the combined occupancy update and in which input wins.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/fbq_align.sv
module fbq_align #(
  parameter int CHUNK = 16,
  localparam int OW  = $clog2(CHUNK),
  localparam int CCW = $clog2(CHUNK + 1)
) (
  input  logic [CHUNK*8-1:0] chunk_i,
  input  logic [OW-1:0]      offset_i,
  output logic [CHUNK*8-1:0] bytes_o,
  output logic [CCW-1:0]     count_o
);
  // drop leading bytes so the first useful byte lands in lane 0
  assign bytes_o = chunk_i >> {offset_i, 3'b000};
  assign count_o = CCW'(CHUNK) - CCW'(offset_i);
endmodule

// File: rtl/fbq_store.sv
module fbq_store
  import fbq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CHUNK = 16,
  localparam int OCW = $clog2(DEPTH + 1),
  localparam int CCW = $clog2(CHUNK + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               push_i,
  input  logic [CCW-1:0]     push_cnt_i,
  input  logic [CHUNK*8-1:0] push_data_i,
  input  logic [OCW-1:0]     pop_cnt_i,
  output logic [DEPTH*8-1:0] q_o,
  output logic [OCW-1:0]     occ_o
);
  byte_t          mem_q [DEPTH];
  byte_t          mem_n [DEPTH];
  logic [OCW-1:0] occ_q, occ_n;

  always_comb begin
    int keep, add, src, dst;
    keep = int'(occ_q) - int'(pop_cnt_i);
    add  = push_i ? int'(push_cnt_i) : 0;
    for (int i = 0; i < DEPTH; i++) begin
      src = i + int'(pop_cnt_i);
      dst = i - keep;
      mem_n[i] = '0;
      if (i < keep) begin
        if (src < DEPTH) mem_n[i] = mem_q[src];
      end else if (dst < add && dst < CHUNK) begin
        mem_n[i] = push_data_i[dst*8 +: 8];
      end
    end
    occ_n = flush_i ? '0 : OCW'(keep + add);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      occ_q <= occ_n;
      if (!flush_i)
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign q_o[g*8 +: 8] = mem_q[g];
  end
  assign occ_o = occ_q;

  a_r10_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_q) <= DEPTH);
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> occ_q == '0);
  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !push_i && pop_cnt_i == '0) |=> $stable(occ_q));
  a_r8_grow_from_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && push_i && occ_q == '0) |=> occ_q == OCW'($past(push_cnt_i)));
endmodule

// File: rtl/fbq_window.sv
module fbq_window #(
  parameter int DEPTH = 32,
  parameter int WIN   = 8,
  localparam int OCW = $clog2(DEPTH + 1),
  localparam int WCW = $clog2(WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIN*8-1:0]   head_i,
  input  logic [OCW-1:0]     occ_i,
  input  logic [WCW-1:0]     consume_i,
  output logic [WIN*8-1:0]   win_o,
  output logic [WCW-1:0]     count_o,
  output logic [OCW-1:0]     pop_o
);
  assign count_o = (int'(occ_i) < WIN) ? WCW'(occ_i) : WCW'(WIN);

  for (genvar g = 0; g < WIN; g++) begin : g_lane
    assign win_o[g*8 +: 8] = (g < int'(count_o)) ? head_i[g*8 +: 8] : 8'h00;
  end

  // oversize consume is clamped to what is shown
  assign pop_o = (consume_i > count_o) ? OCW'(count_o) : OCW'(consume_i);

  a_r4_count_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= WIN && int'(count_o) <= int'(occ_i));
  a_r6_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_o) <= int'(count_o));
endmodule

// File: rtl/fetch_byte_queue.sv
module fetch_byte_queue #(
  parameter int CHUNK = 16,
  parameter int DEPTH = 32,
  parameter int WIN   = 8,
  localparam int OW  = $clog2(CHUNK),
  localparam int CCW = $clog2(CHUNK + 1),
  localparam int OCW = $clog2(DEPTH + 1),
  localparam int WCW = $clog2(WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               fetch_valid_i,
  input  logic [CHUNK*8-1:0] fetch_data_i,
  input  logic [OW-1:0]      fetch_offset_i,
  output logic               fetch_stall_o,
  output logic [WIN*8-1:0]   win_data_o,
  output logic [WCW-1:0]     win_count_o,
  input  logic [WCW-1:0]     consume_i
);
  logic [CHUNK*8-1:0] al_bytes;
  logic [CCW-1:0]     al_cnt;
  logic [DEPTH*8-1:0] q_flat;
  logic [OCW-1:0]     occ, pop_raw, pop;
  logic               room, accept;

  fbq_align #(.CHUNK(CHUNK)) i_align (
    .chunk_i  (fetch_data_i),
    .offset_i (fetch_offset_i),
    .bytes_o  (al_bytes),
    .count_o  (al_cnt)
  );

  // room judged on start-of-cycle occupancy: no decode-to-fetch path
  assign room          = (DEPTH - int'(occ)) >= int'(al_cnt);
  assign accept        = fetch_valid_i && !flush_i && room;
  assign fetch_stall_o = fetch_valid_i && !flush_i && !room;
  assign pop           = flush_i ? '0 : pop_raw;

  fbq_window #(.DEPTH(DEPTH), .WIN(WIN)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .head_i    (q_flat[WIN*8-1:0]),
    .occ_i     (occ),
    .consume_i (consume_i),
    .win_o     (win_data_o),
    .count_o   (win_count_o),
    .pop_o     (pop_raw)
  );

  fbq_store #(.DEPTH(DEPTH), .CHUNK(CHUNK)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (accept),
    .push_cnt_i  (al_cnt),
    .push_data_i (al_bytes),
    .pop_cnt_i   (pop),
    .q_o         (q_flat),
    .occ_o       (occ)
  );

  a_r7_stall_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> fetch_valid_i && !flush_i);
  a_r7_stall_keeps_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_stall_o && consume_i == '0) |=> $stable(win_count_o));
  a_r9_flush_clears_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> win_count_o == '0);
endmodule

// File: tb/test_fetch_byte_queue.sv
module test_fetch_byte_queue;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         fvalid = 1'b0;
  logic [127:0] fdata = '0;
  logic [3:0]   foff = '0;
  logic         stall;
  logic [63:0]  wdata;
  logic [3:0]   wcount;
  logic [3:0]   cons = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] mq[$];

  always #10 clk = ~clk;

  fetch_byte_queue i_fetch_byte_queue (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .fetch_valid_i(fvalid),
    .fetch_data_i(fdata), .fetch_offset_i(foff), .fetch_stall_o(stall),
    .win_data_o(wdata), .win_count_o(wcount), .consume_i(cons)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_win();
    logic [63:0] w = '0;
    for (int i = 0; i < 8; i++) if (i < mq.size()) w[i*8 +: 8] = mq[i];
    return w;
  endfunction

  function automatic int exp_cnt();
    return (mq.size() < 8) ? mq.size() : 8;
  endfunction

  task automatic check_window(string tag);
    chk(tag, "count", 64'(wcount), 64'(exp_cnt()));
    chk(tag, "window", wdata, exp_win());
  endtask

  // one cycle; called and returns at a negedge
  task automatic cyc(string tag, bit v, int off, int base, int c, bit fl);
    int ce, need;
    bit rm, es;
    fvalid = v;
    foff   = 4'(off);
    cons   = 4'(c);
    flush  = fl;
    for (int j = 0; j < 16; j++) fdata[j*8 +: 8] = 8'(base + j);
    need = 16 - off;
    rm   = (32 - mq.size()) >= need;
    es   = v && !fl && !rm;
    ce   = fl ? 0 : ((c < exp_cnt()) ? c : exp_cnt());
    #2;
    chk(tag, "stall", 64'(stall), 64'(es));
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      for (int j = 0; j < ce; j++) void'(mq.pop_front());
      if (v && rm) for (int j = off; j < 16; j++) mq.push_back(8'(base + j));
    end
    @(negedge clk);
    fvalid = 1'b0; cons = '0; flush = 1'b0;
    check_window(tag);
  endtask

  task automatic drain(string tag);
    while (mq.size() > 0) cyc(tag, 1'b0, 0, 0, 8, 1'b0);
  endtask

  task automatic t_reset();
    check_window("R1");
    chk("R1", "stall", 64'(stall), 64'(0));
  endtask

  task automatic t_aligned();
    cyc("R2", 1'b1, 0, 8'h10, 0, 1'b0);
    cyc("R4", 1'b0, 0, 0, 5, 1'b0);
    cyc("R4", 1'b0, 0, 0, 8, 1'b0);
    drain("R4");
  endtask

  task automatic t_offsets();
    cyc("R3", 1'b1, 5, 8'h40, 0, 1'b0);
    cyc("R3", 1'b1, 15, 8'h80, 0, 1'b0);
    drain("R3");
    cyc("R3", 1'b1, 15, 8'hA0, 0, 1'b0);
    cyc("R4", 1'b0, 0, 0, 1, 1'b0);
  endtask

  task automatic t_consume();
    cyc("R5", 1'b1, 0, 8'h00, 0, 1'b0);
    cyc("R5", 1'b0, 0, 0, 3, 1'b0);
    cyc("R5", 1'b0, 0, 0, 0, 1'b0);
    cyc("R5", 1'b0, 0, 0, 7, 1'b0);
    cyc("R6", 1'b0, 0, 0, 8, 1'b0);
    cyc("R6", 1'b0, 0, 0, 8, 1'b0);
    cyc("R6", 1'b1, 14, 8'h30, 0, 1'b0);
    cyc("R6", 1'b0, 0, 0, 8, 1'b0);
  endtask

  task automatic t_full();
    cyc("R10", 1'b1, 0, 8'h20, 0, 1'b0);
    cyc("R10", 1'b1, 0, 8'h30, 0, 1'b0);
    cyc("R10", 1'b1, 0, 8'h40, 0, 1'b0);
    cyc("R7", 1'b1, 15, 8'h50, 0, 1'b0);
    cyc("R7", 1'b0, 0, 0, 8, 1'b0);
    cyc("R7", 1'b1, 8, 8'h60, 0, 1'b0);
    cyc("R7", 1'b1, 7, 8'h70, 0, 1'b0);
    cyc("R7", 1'b1, 0, 8'h80, 8, 1'b0);
    drain("R7");
  endtask

  task automatic t_both();
    cyc("R8", 1'b1, 0, 8'h90, 0, 1'b0);
    cyc("R8", 1'b1, 3, 8'hB0, 6, 1'b0);
    cyc("R8", 1'b1, 12, 8'hC0, 8, 1'b0);
    drain("R8");
  endtask

  task automatic t_flush();
    cyc("R9", 1'b1, 0, 8'hD0, 0, 1'b0);
    cyc("R9", 1'b1, 0, 8'hE0, 0, 1'b0);
    cyc("R9", 1'b1, 0, 8'hF0, 4, 1'b1);
    cyc("R9", 1'b1, 9, 8'h11, 0, 1'b0);
    cyc("R9", 1'b0, 0, 0, 8, 1'b1);
  endtask

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_offsets();
    drain("R5");
    t_consume();
    drain("R6");
    t_full();
    t_both();
    t_flush();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule